// File: doc/BRIEF.md
# ECC-Aware DRAM Channel Address Interleaver

This block turns the cache-line index of a system-visible physical address into a DRAM target: one of eight memory controllers, one of that controller's two channels, and the line address inside that channel. The visible capacity is 31/32 of the installed DRAM. Each 4 KiB DRAM page of 64 lines keeps its top two lines hidden for ECC storage. Visible lines are cut into blocks of 62. Each block goes whole to one controller/channel target, picked by a fixed permutation of the low four bits of the block number. For every data line the block also returns the address of the ECC line that covers it.

The translator has three pipeline stages. In the first, the index is multiplied by a reciprocal of 62. In the second, a one-step correction gives the exact quotient and remainder. In the third, the permutation is applied and the channel addresses are formed. Each stage has two occupancy states, empty and full. A stage goes from empty to full when it loads a valid item. It goes back from full to empty when it hands its item on and nothing new arrives. It stays full when it hands its item on and reloads in the same cycle. A full stage whose successor cannot take its item holds that item. Both edges use valid/ready handshakes. An index at or above the visible capacity gives an error flag instead of a target.

Top module: `ecc_line_interleaver`

## Requirements
- R1: With q = index / 62 and sel = q mod 16, the controller is table[sel mod 8] where table = {3,4,2,5,1,6,0,7} for slots 0..7, and the channel is bit 3 of sel (0 for sel 0..7, 1 for sel 8..15).
- R2: The channel line address is (q >> 4) * 64 + (index mod 62), so its low six bits are never 62 or 63.
- R3: The ECC line address is (q >> 4) * 64 + 62 when index mod 62 is below 31, and (q >> 4) * 64 + 63 otherwise.
- R4: An index at or above 31 * 2^(IDX_W-5) is presented with the error flag set, and controller, channel, line and ECC line all zero. A smaller index has the flag clear.
- R5: With the output ready held high, a result is on the outputs after the third rising edge, counting the edge that accepts the index.
- R6: Results leave in the order their indices were accepted, with none lost or duplicated, under any pattern of output stalls.
- R7: While the output is valid and not ready, every output field stays unchanged.
- R8: The input is ready whenever the output is not valid. With the output ready held high, the input takes one index every cycle.
- R9: During reset and right after it, the output is not valid and the input is ready.
- R10: Two consecutive 62-line blocks never map to controllers of the same adjacent pair (0,1), (2,3), (4,5) or (6,7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Index offered |
| in_ready | output | 1 | Index accepted on this edge when valid |
| in_idx | input | IDX_W | Cache-line index of the physical address |
| out_valid | output | 1 | Result presented |
| out_ready | input | 1 | Consumer takes the result |
| out_err | output | 1 | Index beyond visible capacity |
| out_ctrl | output | 3 | Memory controller number |
| out_chan | output | 1 | Channel within the controller |
| out_line | output | IDX_W-4 | Line address inside the channel |
| out_ecc_line | output | IDX_W-4 | ECC line covering this data line |

## Verification
An index accepted on one rising edge moves through three registers. Its result therefore shows up at the third falling edge after the falling edge at which the bench saw the handshake. The bench drives and samples only on falling edges and keeps the acceptance time of every queued index. In the phase without output stalls it requires that exact three-cycle gap. In the stalled phase only order and value are checked against the scoreboard, because stalls stretch the delay, and the bench compares each stalled cycle's outputs with those of the cycle before.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    localparam int unsigned BLOCK_LINES = 62;
    localparam int unsigned PAGE_SHIFT  = 6;
    localparam int unsigned SEL_W       = 4;

    typedef logic [2:0] ctrl_id_t;

    // Slot order chosen so that neighbouring slots never share an adjacent pair.
    function automatic ctrl_id_t slot_to_ctrl(input logic [2:0] slot);
        ctrl_id_t c;
        unique case (slot)
            3'd0: c = 3'd3;
            3'd1: c = 3'd4;
            3'd2: c = 3'd2;
            3'd3: c = 3'd5;
            3'd4: c = 3'd1;
            3'd5: c = 3'd6;
            3'd6: c = 3'd0;
            3'd7: c = 3'd7;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ilv_pipe_ctrl.sv
module ilv_pipe_ctrl #(
    parameter int STAGES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              out_ready,
    output logic              in_ready,
    output logic              out_valid,
    output logic [STAGES-1:0] load
);

    logic [STAGES-1:0] vld;
    logic [STAGES:0]   en;
    logic [STAGES-1:0] feed;

    assign en[STAGES] = out_ready;
    assign feed       = {vld[STAGES-2:0], in_valid};

    for (genvar i = 0; i < STAGES; i++) begin : g_en
        assign en[i] = !vld[i] || en[i+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                if (en[i]) vld[i] <= feed[i];
            end
        end
    end

    assign load      = en[STAGES-1:0];
    assign in_ready  = en[0];
    assign out_valid = vld[STAGES-1];

endmodule

// File: rtl/ilv_recip_mul.sv
module ilv_recip_mul #(
    parameter int IDX_W = 34
) (
    input  logic [IDX_W-1:0] idx,
    output logic [IDX_W-6:0] q_est
);

    localparam int QW    = IDX_W - 5;
    localparam int SHIFT = IDX_W + 6;
    localparam int RCP_W = IDX_W + 1;
    localparam logic [SHIFT:0]   SCALE = {1'b1, {SHIFT{1'b0}}};
    localparam logic [RCP_W-1:0] RCP   = RCP_W'(SCALE / (SHIFT+1)'(62));

    logic [IDX_W+RCP_W-1:0] prod;

    // Floor reciprocal: the estimate is the true quotient or one below it.
    assign prod  = {{RCP_W{1'b0}}, idx} * {{IDX_W{1'b0}}, RCP};
    assign q_est = QW'(prod >> SHIFT);

endmodule

// File: rtl/ilv_div_fix.sv
module ilv_div_fix #(
    parameter int IDX_W = 34
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-6:0] q_est,
    output logic [IDX_W-6:0] q,
    output logic [5:0]       r
);

    localparam int QW = IDX_W - 5;

    logic [IDX_W-1:0] rem_est;
    logic             bump;

    assign rem_est = idx - IDX_W'({5'd0, q_est} * IDX_W'(62));
    assign bump    = rem_est >= IDX_W'(62);
    assign q       = q_est + QW'(bump);
    assign r       = bump ? 6'(rem_est - IDX_W'(62)) : 6'(rem_est);

endmodule

// File: rtl/ilv_target_map.sv
module ilv_target_map
    import ilv_pkg::*;
#(
    parameter int IDX_W = 34
) (
    input  logic [IDX_W-6:0] q,
    input  logic [5:0]       r,
    input  logic             err,
    output ctrl_id_t         ctrl,
    output logic             chan,
    output logic [IDX_W-5:0] line,
    output logic [IDX_W-5:0] ecc_line
);

    localparam int QW   = IDX_W - 5;
    localparam int CH_W = IDX_W - 4;

    logic [SEL_W-1:0] sel;
    logic [QW-5:0]    page;
    logic [5:0]       ecc_off;

    assign sel     = q[SEL_W-1:0];
    assign page    = q[QW-1:SEL_W];
    assign ecc_off = (r < 6'd31) ? 6'd62 : 6'd63;

    always_comb begin
        if (err) begin
            ctrl     = '0;
            chan     = 1'b0;
            line     = '0;
            ecc_line = '0;
        end else begin
            ctrl     = slot_to_ctrl(sel[2:0]);
            chan     = sel[3];
            line     = CH_W'({page, r});
            ecc_line = CH_W'({page, ecc_off});
        end
    end

endmodule

// File: rtl/ecc_line_interleaver.sv
module ecc_line_interleaver
    import ilv_pkg::*;
#(
    parameter int IDX_W = 34
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [IDX_W-1:0] in_idx,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_err,
    output logic [2:0]       out_ctrl,
    output logic             out_chan,
    output logic [IDX_W-5:0] out_line,
    output logic [IDX_W-5:0] out_ecc_line
);

    localparam int STAGES = 3;
    localparam int QW     = IDX_W - 5;
    localparam int CH_W   = IDX_W - 4;
    localparam logic [IDX_W-1:0] CAP = IDX_W'(31) << (IDX_W - 5);

    logic [STAGES-1:0] load;

    logic [QW-1:0]    q_est_c;
    logic [IDX_W-1:0] s1_idx;
    logic [QW-1:0]    s1_qest;
    logic             s1_err;

    logic [QW-1:0]    q_c;
    logic [5:0]       r_c;
    logic [QW-1:0]    s2_q;
    logic [5:0]       s2_r;
    logic             s2_err;

    ctrl_id_t         ctrl_c;
    logic             chan_c;
    logic [CH_W-1:0]  line_c;
    logic [CH_W-1:0]  ecc_c;

    ilv_pipe_ctrl #(.STAGES(STAGES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .load      (load)
    );

    ilv_recip_mul #(.IDX_W(IDX_W)) u_mul (
        .idx   (in_idx),
        .q_est (q_est_c)
    );

    ilv_div_fix #(.IDX_W(IDX_W)) u_fix (
        .idx   (s1_idx),
        .q_est (s1_qest),
        .q     (q_c),
        .r     (r_c)
    );

    ilv_target_map #(.IDX_W(IDX_W)) u_map (
        .q        (s2_q),
        .r        (s2_r),
        .err      (s2_err),
        .ctrl     (ctrl_c),
        .chan     (chan_c),
        .line     (line_c),
        .ecc_line (ecc_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_idx       <= '0;
            s1_qest      <= '0;
            s1_err       <= 1'b0;
            s2_q         <= '0;
            s2_r         <= '0;
            s2_err       <= 1'b0;
            out_err      <= 1'b0;
            out_ctrl     <= '0;
            out_chan     <= 1'b0;
            out_line     <= '0;
            out_ecc_line <= '0;
        end else begin
            if (load[0]) begin
                s1_idx  <= in_idx;
                s1_qest <= q_est_c;
                s1_err  <= in_idx >= CAP;
            end
            if (load[1]) begin
                s2_q   <= q_c;
                s2_r   <= r_c;
                s2_err <= s1_err;
            end
            if (load[2]) begin
                out_err      <= s2_err;
                out_ctrl     <= ctrl_c;
                out_chan     <= chan_c;
                out_line     <= line_c;
                out_ecc_line <= ecc_c;
            end
        end
    end

endmodule

// File: rtl/ilv_checker.sv
module ilv_checker #(
    parameter int IDX_W = 34
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_err,
    input logic [2:0]       out_ctrl,
    input logic             out_chan,
    input logic [IDX_W-5:0] out_line,
    input logic [IDX_W-5:0] out_ecc_line
);

    localparam int CH_W = IDX_W - 4;

    AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready); // R8

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid &&
        $stable({out_err, out_ctrl, out_chan, out_line, out_ecc_line}))); // R7

    AST_DATA_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err) |-> (out_line[5:0] < 6'd62)); // R2

    AST_ECC_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err) |-> (out_ecc_line[CH_W-1:6] == out_line[CH_W-1:6]
        && out_ecc_line[5:1] == 5'b11111)); // R3

    AST_ECC_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err) |-> (out_ecc_line[0] == (out_line[5:0] >= 6'd31))); // R3

    AST_ERR_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> (out_ctrl == 3'd0 && !out_chan
        && out_line == '0 && out_ecc_line == '0)); // R4

endmodule

bind ecc_line_interleaver ilv_checker #(.IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_err      (out_err),
    .out_ctrl     (out_ctrl),
    .out_chan     (out_chan),
    .out_line     (out_line),
    .out_ecc_line (out_ecc_line)
);

// File: tb/ecc_line_interleaver_test.sv
module ecc_line_interleaver_test;

    localparam int IW = 34;
    localparam int CW = IW - 4;
    localparam longint unsigned CAP  = 64'd31 << (IW - 5);
    localparam longint unsigned FULL = 64'd1 << IW;
    localparam int WATCHDOG = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          out_ready = 1'b0;
    logic [IW-1:0] in_idx = '0;
    logic          in_ready;
    logic          out_valid;
    logic          out_err;
    logic [2:0]    out_ctrl;
    logic          out_chan;
    logic [CW-1:0] out_line;
    logic [CW-1:0] out_ecc_line;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit timed_out = 1'b0;
    bit have_last = 1'b0;
    longint unsigned last_q = 0;
    int last_ctrl = 0;

    logic [IW-1:0] stim_q[$];
    logic [IW-1:0] exp_q[$];
    int            acc_q[$];

    always #2 clk = ~clk;

    ecc_line_interleaver #(.IDX_W(IW)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_idx       (in_idx),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_err      (out_err),
        .out_ctrl     (out_ctrl),
        .out_chan     (out_chan),
        .out_line     (out_line),
        .out_ecc_line (out_ecc_line)
    );

    task automatic check(input bit ok, input string req,
                         input longint unsigned act, input longint unsigned exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int ref_ctrl(input longint unsigned idx);
        int slot;
        slot = int'((idx / 62) % 8);
        case (slot)
            0: return 3;
            1: return 4;
            2: return 2;
            3: return 5;
            4: return 1;
            5: return 6;
            6: return 0;
            default: return 7;
        endcase
    endfunction

    function automatic logic [2*CW+5:0] snap();
        return {out_valid, out_err, out_ctrl, out_chan, out_line, out_ecc_line};
    endfunction

    task automatic compare(input longint unsigned idx);
        longint unsigned q, r, base;
        bit e;
        q = idx / 62;
        r = idx % 62;
        base = (q >> 4) * 64;
        e = idx >= CAP;
        check(out_err == e, "R4 error flag", out_err, e);
        if (e) begin
            check(out_ctrl == 0 && !out_chan && out_line == 0 && out_ecc_line == 0,
                  "R4 zero fields", out_line, 0);
        end else begin
            check(out_ctrl == 3'(ref_ctrl(idx)), "R1 controller", out_ctrl, ref_ctrl(idx));
            check(out_chan == ((q % 16) >= 8), "R1 channel", out_chan, (q % 16) >= 8);
            check(out_line == CW'(base + r), "R2 line address", out_line, base + r);
            check(out_ecc_line == CW'(base + ((r < 31) ? 62 : 63)), "R3 ECC line",
                  out_ecc_line, base + ((r < 31) ? 62 : 63));
            if (have_last && q == last_q + 1)
                check((out_ctrl >> 1) != 3'(last_ctrl >> 1), "R10 non-adjacent blocks",
                      out_ctrl, last_ctrl);
            have_last = 1'b1;
            last_q    = q;
            last_ctrl = int'(out_ctrl);
        end
    endtask

    task automatic run_phase(input bit stall);
        logic [IW-1:0]     cur = '0;
        bit                have = 1'b0;
        bit                held_v = 1'b0;
        logic [2*CW+5:0]   held = '0;
        logic [IW-1:0]     e;
        int                ac;
        while ((stim_q.size() > 0 || have || exp_q.size() > 0) && !timed_out) begin
            @(negedge clk);
            cyc++;
            if (cyc > WATCHDOG) begin
                timed_out = 1'b1;
                check(1'b0, "watchdog", cyc, WATCHDOG);
                break;
            end
            if (!have && stim_q.size() > 0) begin
                cur  = stim_q.pop_front();
                have = 1'b1;
            end
            in_valid  = have;
            in_idx    = have ? cur : '0;
            out_ready = stall ? ($urandom_range(0, 3) != 0) : 1'b1;
            #1;
            if (held_v) check(snap() == held, "R7 hold while stalled", snap(), held);
            held_v = out_valid && !out_ready;
            held   = snap();
            if (!out_valid) check(in_ready, "R8 ready when idle", in_ready, 1);
            if (!stall && in_valid) check(in_ready, "R8 full rate", in_ready, 1);
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected output", 1, 0);
                end else begin
                    e  = exp_q.pop_front();
                    ac = acc_q.pop_front();
                    compare(e);
                    if (!stall) check(cyc - ac == 3, "R5 latency", cyc - ac, 3);
                end
            end
            if (in_valid && in_ready) begin
                exp_q.push_back(cur);
                acc_q.push_back(cyc);
                have = 1'b0;
            end
        end
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b0;
    endtask

    initial begin
        longint unsigned v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        #1;
        check(!out_valid, "R9 reset out_valid", out_valid, 0);
        check(in_ready, "R9 reset in_ready", in_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!out_valid && in_ready, "R9 after reset", out_valid, 0);

        // Directed corners, no stalls.
        foreach (stim_q[i]) stim_q.delete(i);
        stim_q.push_back(IW'(0));
        stim_q.push_back(IW'(30));
        stim_q.push_back(IW'(31));
        stim_q.push_back(IW'(61));
        stim_q.push_back(IW'(62));
        stim_q.push_back(IW'(123));
        stim_q.push_back(IW'(991));
        stim_q.push_back(IW'(992));
        stim_q.push_back(IW'(CAP - 1));
        stim_q.push_back(IW'(CAP));
        stim_q.push_back(IW'(CAP + 5));
        stim_q.push_back(IW'(FULL - 1));
        for (int b = 0; b < 40; b++) stim_q.push_back(IW'(b * 62 + (b % 62)));
        for (int b = 0; b < 20; b++) stim_q.push_back(IW'(b * 62 + 61));
        run_phase(1'b0);

        // Random indices with random output stalls.
        for (int k = 0; k < 400; k++) begin
            v = {$urandom, $urandom};
            if ($urandom_range(0, 9) == 0) v = CAP + (v % (FULL - CAP));
            else v = v % CAP;
            stim_q.push_back(IW'(v));
        end
        run_phase(1'b1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule